// File: doc/BRIEF.md
# Data Address Generator with Delayed Register Writes

This block forms the 16-bit effective address of a data-memory operand for each instruction of a DSP core. It keeps eight address pointers and eight offsets. The instruction decoder supplies a mode, a pointer index, a full-width absolute address and a 6-bit short address. The block returns the effective address combinationally and, when the instruction completes, updates the selected pointer as the mode requires. All arithmetic is linear and wraps modulo 2^16.

A one-cycle `step` strobe marks the end of each instruction. Pointers and offsets can also be loaded by move operations through a write port. Such a load is held in a shadow stage for one instruction. The instruction that immediately follows therefore still sees the old contents, and the instruction after that sees the new value.

Top module: `addr_gen_unit`

## Requirements
- R1: Mode 0 (post-increment) and mode 1 (post-decrement) output pointer `sel` as `ea`. When `step` is high with `use_ea` = 1, that pointer becomes its old value plus 1 (mode 0) or minus 1 (mode 1).
- R2: Mode 2 (post-add offset) and mode 3 (post-subtract offset) output pointer `sel` as `ea`. When `step` is high with `use_ea` = 1, that pointer becomes pointer + offset `sel` (mode 2) or pointer − offset `sel` (mode 3).
- R3: All address arithmetic is 16 bits wide and wraps modulo 65536. For example, 0 − 1 gives 0xFFFF and 0xFFF0 + 0x0020 gives 0x0010.
- R4: Mode 4 (indexed) outputs pointer + offset `sel` as `ea` and never changes the pointer.
- R5: Mode 5 (pre-decrement) outputs pointer − 1 as `ea`. When `step` is high with `use_ea` = 1, the pointer takes that same value.
- R6: Mode 6 (absolute) outputs `abs_addr` as `ea` and changes no register.
- R7: Mode 7 (short absolute) outputs `short_addr` zero-extended to 16 bits and changes no register.
- R8: A write is presented on `wr_en`, `wr_ofs` (0 selects a pointer, 1 selects an offset), `wr_idx` and `wr_data`, and is taken on a `step`. It does not affect `ea` during the next instruction. It does affect `ea` from the instruction after that onward.
- R9: Pointers change only on a `step` cycle. A step with `use_ea` = 0 leaves every pointer unchanged.
- R10: Suppose a staged write commits on the same step on which a mode update targets the same pointer. The written value wins.
- R11: After reset, every pointer and offset is zero and no write is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | One-cycle end-of-instruction strobe |
| use_ea | input | 1 | Current instruction addresses memory; enables the pointer update |
| mode | input | 3 | Addressing mode code (0..7, see R1–R7) |
| sel | input | 3 | Pointer/offset index |
| abs_addr | input | 16 | Full absolute address |
| short_addr | input | 6 | Short absolute address |
| wr_en | input | 1 | Move-type register write request |
| wr_ofs | input | 1 | Write target: 0 pointer, 1 offset |
| wr_idx | input | 3 | Write target index |
| wr_data | input | 16 | Write data |
| ea | output | 16 | Effective address |

## Verification
A wrong pointer or offset appears on `ea` as soon as an instruction selects that register in a register-based mode. That is the same instruction for the value itself, and the next instruction for a bad update. A shadow stage that commits too early or too late shows up as an address that is off by exactly one instruction. This is visible on the second instruction after the move that loaded the register. A wrong choice between a committing write and a same-pointer update is exposed by reading that pointer on the following instruction.

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW   = 16,
  parameter int SW   = 6,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          use_ea,
  input  logic [2:0]    mode,
  input  logic [IW-1:0] sel,
  input  logic [AW-1:0] abs_addr,
  input  logic [SW-1:0] short_addr,
  input  logic          wr_en,
  input  logic          wr_ofs,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] ea
);

  logic [AW-1:0] ptr [NREG];
  logic [AW-1:0] ofs [NREG];

  logic          pend_v;
  logic          pend_ofs;
  logic [IW-1:0] pend_idx;
  logic [AW-1:0] pend_data;

  logic [AW-1:0] cur_p, cur_o, nxt_p;
  logic          upd;

  assign cur_p = ptr[sel];
  assign cur_o = ofs[sel];

  always_comb begin
    ea    = cur_p;
    nxt_p = cur_p;
    upd   = 1'b0;
    case (mode)
      3'd0: begin nxt_p = cur_p + AW'(1); upd = 1'b1; end
      3'd1: begin nxt_p = cur_p - AW'(1); upd = 1'b1; end
      3'd2: begin nxt_p = cur_p + cur_o;  upd = 1'b1; end
      3'd3: begin nxt_p = cur_p - cur_o;  upd = 1'b1; end
      3'd4: ea = cur_p + cur_o;
      3'd5: begin nxt_p = cur_p - AW'(1); ea = nxt_p; upd = 1'b1; end
      3'd6: ea = abs_addr;
      default: ea = {{(AW-SW){1'b0}}, short_addr};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        ptr[i] <= '0;
        ofs[i] <= '0;
      end
      pend_v    <= 1'b0;
      pend_ofs  <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else if (step) begin
      if (use_ea && upd) ptr[sel] <= nxt_p;
      if (pend_v) begin
        if (pend_ofs) ofs[pend_idx] <= pend_data;
        else          ptr[pend_idx] <= pend_data;
      end
      pend_v    <= wr_en;
      pend_ofs  <= wr_ofs;
      pend_idx  <= wr_idx;
      pend_data <= wr_data;
    end
  end

endmodule

// File: rtl/addr_gen_unit_chk.sv
module addr_gen_unit_chk #(
  parameter int AW = 16,
  parameter int SW = 6,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          use_ea,
  input logic [2:0]    mode,
  input logic [IW-1:0] sel,
  input logic [AW-1:0] abs_addr,
  input logic [SW-1:0] short_addr,
  input logic [AW-1:0] ea,
  input logic          pend_v
);

  AST_ABS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd6 |-> ea == abs_addr); // R6

  AST_SHORT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd7 |-> (ea[AW-1:SW] == '0 && ea[SW-1:0] == short_addr)); // R7

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && $stable(mode) && $stable(sel) && $stable(abs_addr) && $stable(short_addr))
      |=> (!$stable(mode) || !$stable(sel) || !$stable(abs_addr) || !$stable(short_addr) || $stable(ea))); // R9

  AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && use_ea && mode == 3'd0 && !pend_v)
      |=> (mode != 3'd0 || sel != $past(sel) || ea == $past(ea) + AW'(1))); // R1

  AST_INDEXED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == 3'd4 && !pend_v)
      |=> (mode != 3'd4 || sel != $past(sel) || ea == $past(ea))); // R4

  AST_PRE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && use_ea && mode == 3'd5 && !pend_v)
      |=> (mode != 3'd5 || sel != $past(sel) || ea == $past(ea) - AW'(1))); // R5

endmodule

bind addr_gen_unit addr_gen_unit_chk #(.AW(AW), .SW(SW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .use_ea(use_ea), .mode(mode),
  .sel(sel), .abs_addr(abs_addr), .short_addr(short_addr), .ea(ea),
  .pend_v(pend_v)
);

// File: tb/tb_addr_gen_unit.sv
`timescale 1ns/1ps
module tb_addr_gen_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0, use_ea = 1'b0, wr_en = 1'b0, wr_ofs = 1'b0;
  logic [2:0]  mode = 3'd0, sel = 3'd0, wr_idx = 3'd0;
  logic [15:0] abs_addr = '0, wr_data = '0;
  logic [5:0]  short_addr = '0;
  logic [15:0] ea;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_gen_unit dut (.*);

  typedef struct packed {
    logic        we;
    logic        wo;
    logic [2:0]  wi;
    logic [15:0] wd;
    logic        ue;
    logic [2:0]  md;
    logic [2:0]  sl;
    logic [15:0] ab;
    logic [5:0]  sh;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,3'd1,16'h1000, 1'b0,3'd6,3'd0,16'hABCD,6'h00, 16'hABCD}, // R6, stage R1 write
    '{1'b1,1'b1,3'd1,16'h0010, 1'b1,3'd0,3'd1,16'h0000,6'h00, 16'h0000}, // R8 not yet visible; R10 commit vs update
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd0,3'd1,16'h0000,6'h00, 16'h1000}, // R8 visible, R10 write won
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd2,3'd1,16'h0000,6'h00, 16'h1001}, // R1 post-inc took effect
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd3,3'd1,16'h0000,6'h00, 16'h1011}, // R2 +N
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd1,3'd1,16'h0000,6'h00, 16'h1001}, // R2 -N
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd4,3'd1,16'h0000,6'h00, 16'h1010}, // R1 post-dec, R4 indexed
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd5,3'd1,16'h0000,6'h00, 16'h0FFF}, // R4 kept, R5 pre-dec
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd0,3'd1,16'h0000,6'h00, 16'h0FFF}, // R5 stored
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd7,3'd1,16'hFFFF,6'h3F, 16'h003F}, // R7 zero-extend
    '{1'b0,1'b0,3'd0,16'h0000, 1'b0,3'd0,3'd1,16'h0000,6'h00, 16'h1000}, // R7 no update; R9 use_ea=0
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd0,3'd1,16'h0000,6'h00, 16'h1000}, // R9 unchanged
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd5,3'd2,16'h0000,6'h00, 16'hFFFF}, // R3 wrap below zero
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd0,3'd2,16'h0000,6'h00, 16'hFFFF}, // R3 stored
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd4,3'd2,16'h0000,6'h00, 16'h0000}, // R3 wrap above FFFF
    '{1'b0,1'b0,3'd0,16'h0000, 1'b1,3'd1,3'd1,16'h0000,6'h00, 16'h1001}  // R1
  };

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (ea !== exp) begin
      n_fail++;
      $display("FAIL %s: ea=%h expected %h", req, ea, exp);
    end
  endtask

  task automatic set_in(input vec_t v);
    wr_en = v.we; wr_ofs = v.wo; wr_idx = v.wi; wr_data = v.wd;
    use_ea = v.ue; mode = v.md; sel = v.sl; abs_addr = v.ab; short_addr = v.sh;
  endtask

  task automatic do_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic instr(input logic we, input logic wo, input logic [2:0] wi,
                       input logic [15:0] wd, input logic ue, input logic [2:0] md,
                       input logic [2:0] sl, input string req, input logic [15:0] exp);
    @(negedge clk);
    set_in('{we, wo, wi, wd, ue, md, sl, 16'h0, 6'h0, 16'h0});
    #1 check(req, exp);
    do_step();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_in(TBL[i]);
      #1 check($sformatf("vector %0d", i), TBL[i].exp);
      do_step();
    end

    // R11: reset clears all pointers, offsets and any staged write
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd3; wr_data = 16'h5555; use_ea = 1'b0;
    do_step();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wr_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sel = 3'(i); mode = 3'd4;
      #1 check("R11 pointer+offset zero", 16'h0000);
    end
    do_step();
    do_step();
    mode = 3'd0; sel = 3'd3;
    #1 check("R11 staged write dropped", 16'h0000);

    // R9: no step, no change
    @(negedge clk);
    use_ea = 1'b1; mode = 3'd0; sel = 3'd5; wr_en = 1'b1; wr_idx = 3'd5; wr_data = 16'h7777;
    repeat (5) @(negedge clk);
    #1 check("R9 held without step", 16'h0000);
    wr_en = 1'b0;

    // R8 with offset write, R2 and R3 wrap on +N
    instr(1'b1, 1'b0, 3'd4, 16'hFFF0, 1'b0, 3'd6, 3'd0, "R6 abs zero", 16'h0000);
    instr(1'b1, 1'b1, 3'd4, 16'h0020, 1'b0, 3'd4, 3'd4, "R8 pointer not yet", 16'h0000);
    instr(1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd4, 3'd4, "R8 pointer seen, offset not yet", 16'hFFF0);
    instr(1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd2, 3'd4, "R2 post-add source", 16'hFFF0);
    instr(1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 3'd4, "R3 wrap on +N", 16'h0010);
    instr(1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd4, 3'd4, "R8 offset seen", 16'h0030);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule